// File: doc/BRIEF.md
# Time-Multiplexed Debug Output Port

This block carries a wide internal debug word off the chip on fewer pins. It runs on a fast clock that is an integer multiple of the design clock and is phase-locked to it. A one-cycle `slow_edge` pulse marks the fast edge that lines up with each design-clock edge. On that edge the block registers the whole debug word. It then drives the word out as `RATIO` slices, one slice per fast cycle, starting with the least significant slice. The pin count is the word width divided by `RATIO`, and `RATIO` may be 2 or 4.

A frame marker is high only while slice 0 is on the pins. An external capture tool can therefore find the word boundary and line its pattern triggers up with whole words. The port is synchronous only: each word it sends is cycle accurate, and it says nothing about timing between clock edges.

A companion reconstructor, `dbg_tdm_rebuild`, is used for self-checking. It waits for the first frame marker, joins the slices that follow in send order, and raises a one-cycle valid flag with each word it rebuilds.

Top module: `dbg_tdm_port`

## Requirements
- R1: After reset, and until the first `slow_edge`, `tdm_pins` is zero and `tdm_frame` is low, whatever `dbg_in` holds.
- R2: In the fast cycle after an edge that samples `slow_edge` high, `tdm_frame` is high and `tdm_pins` carries bits [SLICE_W-1:0] of the `dbg_in` value sampled on that edge.
- R3: In each later fast cycle k (1 to RATIO-1), `tdm_pins` carries bits [(k+1)*SLICE_W-1 : k*SLICE_W] of the same sample, and `tdm_frame` is low.
- R4: All slices of one frame come from the single sample taken at its `slow_edge`. Changes on `dbg_in` after that edge have no effect on them.
- R5: Once all RATIO slices have been sent and no new `slow_edge` has arrived, `tdm_pins` is zero and `tdm_frame` is low.
- R6: A `slow_edge` that arrives before a frame is finished restarts the sequence at slice 0 with the new sample, and `tdm_frame` goes high again.
- R7: The reconstructor ignores its pin input and never raises `valid` until it has seen a frame marker.
- R8: The reconstructor raises `valid` for exactly one cycle, in the cycle after the last slice of a frame arrives. Its word equals the original sample, with slice k placed at bit offset k*SLICE_W. Back-to-back frames each produce their own word.
- R9: With RATIO=4, a 16-bit word leaves on 4 pins in four ordered slices.
- R10: RATIO must be 2 or 4 and must not exceed CLK_RATIO. Any other setting is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, phase-locked to the design clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_edge | input | 1 | One-cycle pulse on the fast cycle aligned with a design-clock edge |
| dbg_in | input | WORD_W | Debug word from the design-clock domain |
| tdm_pins | output | WORD_W/RATIO | Current slice on the output pins |
| tdm_frame | output | 1 | High while slice 0 is on the pins |

## Verification
The bench changes `dbg_in` right after each capture. A design that slices the live input instead of the registered sample would send a torn word. It fires a new `slow_edge` partway through a 4:1 frame. A counter that does not restart would keep sending old slices, or would fail to raise the marker. It checks that the pins return to zero after the last slice, which catches a counter that wraps and sends stale data again. It also feeds the reconstructor non-zero slices with no marker, then sends a valid frame. A receiver that locks too early, sends the slices in the wrong order, or raises `valid` more than once per frame produces a wrong or extra word.

// File: rtl/dbg_tdm_pkg.sv
package dbg_tdm_pkg;

    // Width of a slot counter that must also hold the idle value RATIO.
    function automatic int slot_cnt_w(input int ratio);
        return $clog2(ratio + 1);
    endfunction

    function automatic bit ratio_legal(input int ratio, input int clk_ratio);
        return ((ratio == 2) || (ratio == 4)) && (ratio <= clk_ratio);
    endfunction

    typedef enum logic [0:0] {
        LANE_IDLE = 1'b0,
        LANE_SEND = 1'b1
    } lane_state_e;

endpackage

// File: rtl/dbg_tdm_capture.sv
module dbg_tdm_capture #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] d_in,
    output logic [WORD_W-1:0] q_out
);
    logic [WORD_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (load) begin
            hold_q <= d_in;
        end
    end

    assign q_out = hold_q;

    // Between sample points the held word does not move.
    AST_HOLD_COHERENT: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(hold_q)); // R4

endmodule

// File: rtl/dbg_tdm_slicer.sv
module dbg_tdm_slicer
    import dbg_tdm_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int RATIO  = 2,
    localparam int SLICE_W = WORD_W / RATIO,
    localparam int CW      = slot_cnt_w(RATIO)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic [WORD_W-1:0]  word,
    output logic [SLICE_W-1:0] pins,
    output logic               frame
);
    logic [CW-1:0] slot_q;
    lane_state_e   state;

    // slot_q == RATIO means idle.
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= CW'(RATIO);
        end else if (restart) begin
            slot_q <= '0;
        end else if (slot_q != CW'(RATIO)) begin
            slot_q <= slot_q + 1'b1;
        end
    end

    assign state = (slot_q == CW'(RATIO)) ? LANE_IDLE : LANE_SEND;

    always_comb begin
        pins = '0;
        if (state == LANE_SEND) begin
            for (int i = 0; i < RATIO; i++) begin
                if (slot_q == CW'(i)) begin
                    pins = word[i*SLICE_W +: SLICE_W];
                end
            end
        end
    end

    assign frame = (slot_q == '0);

    AST_RESTART_MARK: assert property (@(posedge clk) disable iff (rst)
        restart |=> frame); // R6

    AST_MARK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (frame && !restart) |=> !frame); // R3

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!restart && $past(slot_q) == CW'(RATIO - 1) && !$past(restart)) |=> (pins == '0 && !frame)); // R5

endmodule

// File: rtl/dbg_tdm_rebuild.sv
module dbg_tdm_rebuild
    import dbg_tdm_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int RATIO  = 2,
    localparam int SLICE_W = WORD_W / RATIO,
    localparam int CW      = slot_cnt_w(RATIO)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SLICE_W-1:0] pins,
    input  logic               frame,
    output logic [WORD_W-1:0]  word,
    output logic               valid
);
    logic              locked_q;
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     sel;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_next;
    logic [WORD_W-1:0] word_q;
    logic              valid_q;
    logic              take;
    logic              last;

    assign sel  = frame ? '0 : cnt_q;
    assign take = frame || (locked_q && cnt_q != CW'(RATIO));
    assign last = !frame && locked_q && (cnt_q == CW'(RATIO - 1));

    always_comb begin
        acc_next = acc_q;
        for (int i = 0; i < RATIO; i++) begin
            if (sel == CW'(i)) begin
                acc_next[i*SLICE_W +: SLICE_W] = pins;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
            cnt_q    <= CW'(RATIO);
            acc_q    <= '0;
            word_q   <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (frame) begin
                locked_q <= 1'b1;
                cnt_q    <= CW'(1);
            end else if (take) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (take) begin
                acc_q <= acc_next;
            end
            if (last) begin
                word_q  <= acc_next;
                valid_q <= 1'b1;
            end
        end
    end

    assign word  = word_q;
    assign valid = valid_q;

    AST_NO_VALID_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        !locked_q |=> !valid_q); // R7

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q); // R8

endmodule

// File: rtl/dbg_tdm_port.sv
module dbg_tdm_port
    import dbg_tdm_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int RATIO     = 2,
    parameter int CLK_RATIO = 2,
    localparam int SLICE_W  = WORD_W / RATIO
) (
    input  logic               clk_fast,
    input  logic               rst,
    input  logic               slow_edge,
    input  logic [WORD_W-1:0]  dbg_in,
    output logic [SLICE_W-1:0] tdm_pins,
    output logic               tdm_frame
);
    logic [WORD_W-1:0] sample;

    initial begin
        AST_RATIO_LEGAL: assert (ratio_legal(RATIO, CLK_RATIO)); // R10
    end

    dbg_tdm_capture #(
        .WORD_W (WORD_W)
    ) capture_i (
        .clk   (clk_fast),
        .rst   (rst),
        .load  (slow_edge),
        .d_in  (dbg_in),
        .q_out (sample)
    );

    dbg_tdm_slicer #(
        .WORD_W (WORD_W),
        .RATIO  (RATIO)
    ) slicer_i (
        .clk     (clk_fast),
        .rst     (rst),
        .restart (slow_edge),
        .word    (sample),
        .pins    (tdm_pins),
        .frame   (tdm_frame)
    );

endmodule

// File: tb/dbg_tdm_port_tb.sv
`timescale 1ns/1ps
module dbg_tdm_port_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    // 2:1 lane, 8-bit word, checked through its own reconstructor
    logic       se2 = 1'b0;
    logic [7:0] dbg2 = '0;
    logic [3:0] pins2;
    logic       frame2;
    logic [7:0] word2;
    logic       valid2;

    // 4:1 lane, 16-bit word
    logic        se4 = 1'b0;
    logic [15:0] dbg4 = '0;
    logic [3:0]  pins4;
    logic        frame4;

    // Reconstructor driven directly by the bench
    logic [3:0]  rx_pins = '0;
    logic        rx_frame = 1'b0;
    logic [15:0] rx_word;
    logic        rx_valid;

    dbg_tdm_port #(.WORD_W(8), .RATIO(2), .CLK_RATIO(2)) dut_i (
        .clk_fast(clk), .rst(rst), .slow_edge(se2), .dbg_in(dbg2),
        .tdm_pins(pins2), .tdm_frame(frame2));

    dbg_tdm_rebuild #(.WORD_W(8), .RATIO(2)) rebuild2_i (
        .clk(clk), .rst(rst), .pins(pins2), .frame(frame2),
        .word(word2), .valid(valid2));

    dbg_tdm_port #(.WORD_W(16), .RATIO(4), .CLK_RATIO(4)) dut4_i (
        .clk_fast(clk), .rst(rst), .slow_edge(se4), .dbg_in(dbg4),
        .tdm_pins(pins4), .tdm_frame(frame4));

    dbg_tdm_rebuild #(.WORD_W(16), .RATIO(4)) rebuild4_i (
        .clk(clk), .rst(rst), .pins(rx_pins), .frame(rx_frame),
        .word(rx_word), .valid(rx_valid));

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    localparam int NV = 6;
    localparam logic [7:0] VEC [NV] = '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81, 8'h7E};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send2(input logic [7:0] w);
        @(negedge clk); dbg2 = w; se2 = 1'b1;
        @(negedge clk);
        chk(frame2 == 1'b1, "R2 frame2", int'(frame2), 1);
        chk(pins2 == w[3:0], "R2 slice0", int'(pins2), int'(w[3:0]));
        chk(valid2 == 1'b0, "R8 no early valid", int'(valid2), 0);
        se2 = 1'b0; dbg2 = ~w;
        @(negedge clk);
        chk(frame2 == 1'b0, "R3 frame2 low", int'(frame2), 0);
        chk(pins2 == w[7:4], "R4 slice1 coherent", int'(pins2), int'(w[7:4]));
        @(negedge clk);
        chk(valid2 == 1'b1, "R8 valid", int'(valid2), 1);
        chk(word2 == w, "R8 word", int'(word2), int'(w));
        chk(pins2 == 4'h0 && !frame2, "R5 idle zero", int'(pins2), 0);
        @(negedge clk);
        chk(valid2 == 1'b0, "R8 single pulse", int'(valid2), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        dbg2 = 8'hC3; dbg4 = 16'hBEEF;
        repeat (2) @(negedge clk);
        chk(pins2 == 0 && !frame2, "R1 quiet after reset", int'(pins2), 0);
        chk(pins4 == 0 && !frame4, "R1 quiet after reset 4:1", int'(pins4), 0);
        chk(!valid2, "R1 no valid", int'(valid2), 0);

        for (int i = 0; i < NV; i++) send2(VEC[i]);

        // R8 back-to-back frames at full rate
        @(negedge clk); dbg2 = 8'h12; se2 = 1'b1;
        @(negedge clk); se2 = 1'b0;
        @(negedge clk); dbg2 = 8'h34; se2 = 1'b1;
        @(negedge clk); se2 = 1'b0;
        chk(valid2 && word2 == 8'h12, "R8 stream word A", int'(word2), 'h12);
        chk(frame2 && pins2 == 4'h4, "R2 stream slice0 B", int'(pins2), 4);
        @(negedge clk);
        chk(!valid2, "R8 stream gap", int'(valid2), 0);
        @(negedge clk);
        chk(valid2 && word2 == 8'h34, "R8 stream word B", int'(word2), 'h34);

        // R9 4:1 slicing with coherence and idle
        @(negedge clk); dbg4 = 16'h9C5A; se4 = 1'b1;
        @(negedge clk);
        chk(frame4 && pins4 == 4'hA, "R9 slice0", int'(pins4), 'hA);
        se4 = 1'b0; dbg4 = 16'h0000;
        @(negedge clk);
        chk(!frame4 && pins4 == 4'h5, "R9 slice1", int'(pins4), 5);
        @(negedge clk);
        chk(!frame4 && pins4 == 4'hC, "R9 slice2", int'(pins4), 'hC);
        @(negedge clk);
        chk(!frame4 && pins4 == 4'h9, "R9 slice3", int'(pins4), 9);
        @(negedge clk);
        chk(!frame4 && pins4 == 4'h0, "R5 idle zero 4:1", int'(pins4), 0);

        // R6 restart mid-frame
        @(negedge clk); dbg4 = 16'h4321; se4 = 1'b1;
        @(negedge clk); se4 = 1'b0;
        chk(pins4 == 4'h1, "R6 first A slice", int'(pins4), 1);
        @(negedge clk);
        chk(pins4 == 4'h2, "R6 second A slice", int'(pins4), 2);
        dbg4 = 16'h8765; se4 = 1'b1;
        @(negedge clk); se4 = 1'b0;
        chk(frame4 && pins4 == 4'h5, "R6 restart slice0", int'(pins4), 5);
        @(negedge clk);
        chk(!frame4 && pins4 == 4'h6, "R6 restart slice1", int'(pins4), 6);

        // R7 reconstructor waits for the marker
        @(negedge clk); rx_pins = 4'hF; rx_frame = 1'b0;
        repeat (5) begin
            @(negedge clk);
            chk(!rx_valid && rx_word == 16'h0, "R7 unlocked", int'(rx_word), 0);
        end
        rx_frame = 1'b1; rx_pins = 4'h1;
        @(negedge clk); rx_frame = 1'b0; rx_pins = 4'h2;
        @(negedge clk); rx_pins = 4'h3;
        @(negedge clk); rx_pins = 4'h4;
        @(negedge clk);
        chk(rx_valid && rx_word == 16'h4321, "R8 rebuild order", int'(rx_word), 'h4321);
        rx_pins = 4'hE;
        @(negedge clk);
        chk(!rx_valid, "R8 no extra word", int'(rx_valid), 0);
        @(negedge clk);
        chk(!rx_valid && rx_word == 16'h4321, "R8 held word", int'(rx_word), 'h4321);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule